// File: doc/BRIEF.md
# Oversampled Serial Frame Receiver with Majority Voting

This block takes an asynchronous serial line that is already synchronized to the core clock. A frame on that line has 10 bits: a low start bit, 8 data bits sent least significant bit first, and a stop bit. A baud generator outside the block supplies a one-cycle `tick` pulse 16 times per bit period. The receiver does nothing between ticks. While it is idle it watches for a high-to-low transition between two consecutive ticks. Such a transition restarts its 16-slot phase counter, so each bit period is measured from the start edge.

Each bit is decided by a 2-of-3 vote over the line values seen in slots 8, 9 and 10 of the bit. If the start bit votes high, it was a glitch: the receiver drops it and goes back to searching for an edge. The vote on the stop bit is the end of the frame. At that point the byte and the stop bit are written to the output registers and the done flag is raised, but only if the acceptance rule holds. Otherwise the frame is dropped silently.

The only data exchange at the block's edge is the done flag and its clear strobe. The flag serves as a one-entry valid indicator. The clear strobe is the only way to release it. There is no back-pressure: while the flag is set, every further frame is lost. All pins are plain control and status levels.

Top module: `vote_rx`

## Requirements
- R1: No frame reception starts while `rx_en` is low. Dropping `rx_en` in the middle of a frame returns the receiver to idle on the next clock, and that frame is never committed.
- R2: An edge is a tick on which `rxd` is 0 while the `rxd` value at the previous tick was 1. That tick counts as slot 0 of the start bit. Bit n of the frame (start = 0) occupies the ticks numbered 16n to 16n+15 counted from the edge tick.
- R3: A bit's value is the majority of the `rxd` values at slots 8, 9 and 10 of that bit. One wrong sample among the three does not change the result.
- R4: If the start bit votes 1, the frame is abandoned and the receiver searches for a new edge. No output changes.
- R5: Frame bits 1 to 8 carry data least significant bit first. On an accepted frame, `rx_data` takes these bits.
- R6: A frame is accepted only when `rx_done` is 0 and either `mp_mode` is 0 or the voted stop bit is 1. On acceptance, `rx_stop` takes the voted stop bit.
- R7: On acceptance, `rx_data`, `rx_stop` and `rx_done`=1 all update on the clock edge where slot 10 of the stop bit is sampled.
- R8: A frame that is not accepted leaves `rx_data`, `rx_stop` and `rx_done` unchanged.
- R9: `rx_done` falls only on a clock where `done_clr` is 1. When `done_clr` and an acceptance fall on the same clock, `rx_done` is 1.
- R10: Right after slot 10 of the stop bit, the receiver is searching for an edge again. A start edge 11 slots into the stop bit is received.
- R11: Reset gives `rx_data`=0, `rx_stop`=0, `rx_done`=0, and the receiver is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxd | input | 1 | Synchronized serial line |
| rx_en | input | 1 | Reception enable |
| mp_mode | input | 1 | Accept only frames whose stop bit is 1 |
| done_clr | input | 1 | Clears `rx_done` |
| rx_data | output | 8 | Last accepted byte |
| rx_stop | output | 1 | Stop bit of the last accepted frame |
| rx_done | output | 1 | Frame-received flag |

## Verification
The assertions assume that `tick` lasts one clock and that `rxd` comes from a synchronizer. The stop-bit acceptance check compares against `mp_mode` one clock earlier, so it also assumes `mp_mode` changes only between frames. The bench raises `tick` on one clock out of every four. It moves `rxd` and `mp_mode` only on falling clock edges that lie between ticks. It changes `rx_en` only between ticks, and it pulses `done_clr` only when no frame is ending.

// File: rtl/vote_rx_pkg.sv
package vote_rx_pkg;
  typedef enum logic [0:0] {RX_IDLE = 1'b0, RX_BUSY = 1'b1} rx_state_t;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/vote_rx_edge.sv
module vote_rx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rxd,
  input  logic arm,
  output logic fall
);
  logic line_q;

  // line value at the previous tick; reset low so a stuck-low line never starts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    line_q <= 1'b0;
    else if (tick) line_q <= rxd;
  end

  assign fall = tick & arm & line_q & ~rxd;
endmodule

// File: rtl/vote_rx_phase.sv
module vote_rx_phase #(
  parameter int OVS = 16,
  localparam int PW = $clog2(OVS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          restart,
  input  logic          run,
  output logic [PW-1:0] phase,
  output logic          last_slot
);
  // phase holds the slot index of the next tick; the edge tick was slot 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           phase <= '0;
    else if (restart)     phase <= PW'(1);
    else if (run && tick) phase <= (phase == PW'(OVS - 1)) ? '0 : phase + PW'(1);
  end

  assign last_slot = tick && run && (phase == PW'(OVS - 1));

  p_restart_aligns_r2: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (phase == PW'(1)));
endmodule

// File: rtl/vote_rx_voter.sv
module vote_rx_voter #(
  parameter int OVS = 16,
  localparam int PW  = $clog2(OVS),
  localparam int MID = OVS / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          run,
  input  logic          rxd,
  input  logic [PW-1:0] phase,
  output logic          bit_ready,
  output logic          bit_val
);
  import vote_rx_pkg::*;
  logic s_first, s_second;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_first  <= 1'b0;
      s_second <= 1'b0;
    end else if (tick && run) begin
      if (phase == PW'(MID))     s_first  <= rxd;
      if (phase == PW'(MID + 1)) s_second <= rxd;
    end
  end

  assign bit_ready = tick && run && (phase == PW'(MID + 2));
  assign bit_val   = vote3(s_first, s_second, rxd);

  // R3: two agreeing stored samples decide regardless of the third
  p_vote_majority_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_ready && (s_first == s_second)) |-> (bit_val == s_first));
endmodule

// File: rtl/vote_rx.sv
module vote_rx #(
  parameter int DATA_BITS = 8,
  parameter int OVS       = 16,
  localparam int PW       = $clog2(OVS),
  localparam int FRAME    = DATA_BITS + 2,
  localparam int IW       = $clog2(FRAME)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 rxd,
  input  logic                 rx_en,
  input  logic                 mp_mode,
  input  logic                 done_clr,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_stop,
  output logic                 rx_done
);
  import vote_rx_pkg::*;

  rx_state_t            state;
  logic [IW-1:0]        bit_idx;
  logic [DATA_BITS-1:0] shreg;
  logic [PW-1:0]        phase;
  logic                 fall, last_slot, bit_ready, bit_val;
  logic                 busy, at_start, at_stop, accept;

  assign busy     = (state == RX_BUSY) && rx_en;
  assign at_start = (bit_idx == '0);
  assign at_stop  = (bit_idx == IW'(FRAME - 1));
  assign accept   = busy && bit_ready && at_stop && !rx_done && (!mp_mode || bit_val);

  vote_rx_edge u_edge (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
    .arm(rx_en && (state == RX_IDLE)), .fall(fall)
  );

  vote_rx_phase #(.OVS(OVS)) u_phase (
    .clk(clk), .rst_n(rst_n), .tick(tick), .restart(fall), .run(busy),
    .phase(phase), .last_slot(last_slot)
  );

  vote_rx_voter #(.OVS(OVS)) u_vote (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(busy), .rxd(rxd),
    .phase(phase), .bit_ready(bit_ready), .bit_val(bit_val)
  );

  // frame sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= RX_IDLE;
      bit_idx <= '0;
      shreg   <= '0;
    end else if (!rx_en) begin
      state   <= RX_IDLE;
    end else if (fall) begin
      state   <= RX_BUSY;
      bit_idx <= '0;
    end else if (busy) begin
      if (bit_ready) begin
        if (at_start && bit_val) state <= RX_IDLE;
        else if (at_stop)        state <= RX_IDLE;
        else if (!at_start)      shreg <= {bit_val, shreg[DATA_BITS-1:1]};
      end
      if (last_slot) bit_idx <= bit_idx + IW'(1);
    end
  end

  // committed outputs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0;
      rx_stop <= 1'b0;
      rx_done <= 1'b0;
    end else if (accept) begin
      rx_data <= shreg;
      rx_stop <= bit_val;
      rx_done <= 1'b1;
    end else if (done_clr) begin
      rx_done <= 1'b0;
    end
  end

  p_off_goes_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (state == RX_IDLE));
  p_accept_rule_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_done) |-> (!$past(mp_mode) || rx_stop));
  p_held_while_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> ($stable(rx_data) && $stable(rx_stop)));
  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !done_clr) |=> rx_done);
  p_idle_after_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bit_ready && at_stop) |=> (state == RX_IDLE));
endmodule

// File: tb/vote_rx_test.sv
module vote_rx_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, rxd = 1'b1, rx_en = 1'b0, mp_mode = 1'b0, done_clr = 1'b0;
  logic [7:0] rx_data;
  logic rx_stop, rx_done;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk; // 250 MHz

  vote_rx uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .rx_en(rx_en),
    .mp_mode(mp_mode), .done_clr(done_clr),
    .rx_data(rx_data), .rx_stop(rx_stop), .rx_done(rx_done)
  );

  // behavioural reference: tick counting since the edge, queue of votes
  bit m_busy, m_line, m_stop, m_done, commit, cstop, v;
  bit [7:0] m_data, m_acc;
  int m_cnt, bi, sl;
  bit votes[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_line = 0; m_data = 0; m_stop = 0; m_done = 0; m_acc = 0;
      votes.delete();
    end else begin
      commit = 0; cstop = 0;
      if (!rx_en) m_busy = 0;
      if (tick) begin
        if (m_busy) begin
          m_cnt++;
          bi = m_cnt / 16;
          sl = m_cnt % 16;
          if (sl >= 8 && sl <= 10) votes.push_back(rxd);
          if (sl == 10) begin
            v = (int'(votes[0]) + int'(votes[1]) + int'(votes[2])) >= 2;
            votes.delete();
            if (bi == 0) begin
              if (v) m_busy = 0;
            end else if (bi <= 8) begin
              m_acc[bi-1] = v;
            end else begin
              m_busy = 0;
              if (!m_done && (!mp_mode || v)) begin commit = 1; cstop = v; end
            end
          end
        end else if (rx_en && m_line && !rxd) begin
          m_busy = 1; m_cnt = 0; votes.delete();
        end
        m_line = rxd;
      end
      if (commit) begin m_data = m_acc; m_stop = cstop; m_done = 1; end
      else if (done_clr) m_done = 0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R5 data vs model", rx_data, m_data);
      chk("R6 stop vs model", rx_stop, m_stop);
      chk("R7 done vs model", rx_done, m_done);
    end
  end

  task automatic slot(input bit val);
    @(negedge clk) rxd = val; tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) slot(1'b1);
  endtask

  task automatic frame(input bit [7:0] b, input bit stp, input int stop_slots, input bit noisy);
    bit val;
    for (int k = 0; k < 10; k++) begin
      val = (k == 0) ? 1'b0 : (k == 9) ? stp : b[k-1];
      for (int s = 0; s < ((k == 9) ? stop_slots : 16); s++)
        slot((noisy && s == 9) ? ~val : val);
    end
  endtask

  task automatic clear_flag();
    @(negedge clk) done_clr = 1'b1;
    @(negedge clk) done_clr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset data", rx_data, 0);
    chk("R11 reset done", rx_done, 0);
    chk("R11 reset stop", rx_stop, 0);
    rst_n = 1'b1;
    // R1: frame with enable low is ignored
    idle(4);
    frame(8'h77, 1, 16, 0); idle(4);
    chk("R1 disabled frame ignored", rx_done, 0);
    rx_en = 1'b1; idle(4);
    // R2/R5/R7: basic frame
    frame(8'hA5, 1, 16, 0); idle(3);
    chk("R5 data A5", rx_data, 8'hA5);
    chk("R7 done set", rx_done, 1);
    // R8: frame while full is dropped
    frame(8'h3C, 1, 16, 0); idle(3);
    chk("R8 data held", rx_data, 8'hA5);
    // R9: clear only by strobe
    chk("R9 still set", rx_done, 1);
    clear_flag();
    chk("R9 cleared", rx_done, 0);
    // R4: glitch start abandoned
    for (int i = 0; i < 6; i++) slot(1'b0);
    idle(30);
    chk("R4 glitch no frame", rx_done, 0);
    chk("R4 data unchanged", rx_data, 8'hA5);
    frame(8'h5A, 1, 16, 0); idle(3);
    chk("R4 next frame ok", rx_data, 8'h5A);
    clear_flag();
    // R3: one bad sample per bit
    frame(8'h96, 1, 16, 1); idle(3);
    chk("R3 noisy data", rx_data, 8'h96);
    clear_flag();
    // R6: multiprocessor rule
    mp_mode = 1'b1;
    frame(8'h11, 0, 16, 0); idle(3);
    chk("R6 stop0 rejected", rx_done, 0);
    chk("R8 reject keeps data", rx_data, 8'h96);
    frame(8'h22, 1, 16, 0); idle(3);
    chk("R6 stop1 accepted", rx_data, 8'h22);
    chk("R6 stop reg 1", rx_stop, 1);
    clear_flag();
    mp_mode = 1'b0;
    frame(8'h33, 0, 16, 0); idle(3);
    chk("R6 stop0 mp off accepted", rx_data, 8'h33);
    chk("R6 stop reg 0", rx_stop, 0);
    clear_flag();
    // R10: short stop then next start
    frame(8'hC3, 1, 11, 0);
    frame(8'h3E, 1, 16, 0); idle(3);
    chk("R10 first of pair", rx_done, 1);
    clear_flag();
    // second frame is lost since flag was set; resend with flag clear
    frame(8'hE1, 1, 11, 0); clear_flag();
    frame(8'h4B, 1, 16, 0); idle(3);
    chk("R10 back-to-back second", rx_data, 8'h4B);
    clear_flag();
    // R1: enable dropped mid-frame
    for (int i = 0; i < 40; i++) slot(i < 16 ? 1'b0 : 1'b1);
    rx_en = 1'b0;
    idle(140);
    rx_en = 1'b1; idle(4);
    chk("R1 midframe drop no commit", rx_done, 0);
    frame(8'h69, 1, 16, 0); idle(3);
    chk("R1 recovers after enable", rx_data, 8'h69);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule